// File: doc/BRIEF.md
# Flash Write-Status Read Multiplexer

This block forms the read-data path of a NOR flash while an embedded program or erase is running or parked in erase-suspend. It tracks the current internal operation, the sector being erased, and the data bit being programmed. On every read strobe it returns one of three things: a status word (polling bit and toggle bits), a suspended-sector marker, or the true array word that the storage around it supplies. It also drives an active-high ready flag and a one-cycle completion pulse.

Real program and erase durations are replaced by cycle-count timers. The erase timer keeps its remaining count while an erase is suspended, so a resume carries on where it stopped. A synchronous reset stands in for the hardware reset pin. It ends whatever is in flight, and the interrupted operation never reports completion.

Top module: `flash_wstat_rdmux`

## Requirements
- R1: While a program is busy, a read returns bit 7 as the inverse of bit 7 of the word being programmed. Once the program completes, reads return `array_data` unchanged.
- R2: While an erase is busy, including the suspend latency, a read returns bit 7 as 0. After the erase completes, reads return `array_data` unchanged. Outside bits 7, 6 and 2, a status read passes `array_data` through.
- R3: Each read during a busy program or erase returns bit 6 from a toggle flop and then inverts that flop. Both toggle flops are cleared to 0 whenever an operation starts: a fresh program or erase, a program issued in suspend, or a resume. The first status read after a start therefore shows bit 6 = 0.
- R4: Bit 2 comes from a second toggle flop. That flop inverts on reads during a busy erase and on reads inside the suspended sector. It holds on reads during a program.
- R5: In the suspended state, a read whose sector (`rd_addr[AW-1:SECT_LSB]`) matches the suspended sector returns bit 7 = 1, bit 6 = 1 and bit 2 toggling. A read in any other sector returns `array_data`.
- R6: `ready` is 0 during a program, an erase, the suspend latency, and a program issued in suspend. It is 1 when idle or suspended.
- R7: Reset forces `ready` = 1, `rd_data` = 0 and `op_done` = 0 in the following cycle. An interrupted operation never raises `op_done`.
- R8: `suspend_req` during a busy erase moves to the suspended state after exactly SUSP_CYCLES clock edges. `ready` rises in that cycle.
- R9: `op_done` is a one-cycle pulse that rises exactly PROG_CYCLES (program) or the remaining erase count (erase) edges after the edge that accepted the start.
- R10: A start, suspend or resume command that arrives while a program is busy, or a start that arrives during an erase, is ignored. `start_prog` takes priority over `start_erase` when both arrive while idle.
- R11: In suspend, `start_prog` to the suspended sector is ignored. `start_prog` to any other sector runs a program that returns to the suspended state when it completes.
- R12: `resume_req` in the suspended state restarts the erase with its remaining count. That count is ERASE_CYCLES minus the edges spent busy before the suspend was accepted. `start_prog` wins over `resume_req` if both arrive together.
- R13: `rd_data` is registered. It changes only in the cycle after a read strobe and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, models the hardware reset pin |
| start_prog | input | 1 | Start a word program at `cmd_addr` with `cmd_data` |
| start_erase | input | 1 | Start a sector erase at the sector of `cmd_addr` |
| suspend_req | input | 1 | Request erase suspend |
| resume_req | input | 1 | Resume a suspended erase |
| cmd_addr | input | AW | Command target address |
| cmd_data | input | DW | Word being programmed |
| rd_strobe | input | 1 | One-cycle read request |
| rd_addr | input | AW | Read address |
| array_data | input | DW | True array contents at `rd_addr` |
| rd_data | output | DW | Registered read result |
| ready | output | 1 | High when idle or suspended |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
The program is tried with a data word whose bit 7 is 1, with back-to-back reads and an all-ones array word. This separates the polling inversion from the toggle flops and shows that bit 2 holds. The erase is read repeatedly, interrupted by an ignored program command, suspended, read inside and outside the suspended sector, programmed in the same and in another sector, and resumed. Together these separate sector membership, toggle-flop clearing and the frozen erase count. A reset in the middle of an erase, followed by a long quiet window, shows that the cancelled operation never raises completion.

// File: rtl/flash_rdmux_pkg.sv
package flash_rdmux_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP_WAIT,
        ST_SUSPENDED,
        ST_SUSP_PROG
    } op_state_t;

    typedef enum logic [1:0] {
        RK_ARRAY,
        RK_PROG,
        RK_ERASE,
        RK_SUSP
    } read_kind_t;

    localparam int POLL_BIT  = 7;
    localparam int TOG_BIT   = 6;
    localparam int STOG_BIT  = 2;
    localparam int NUM_TOG   = 2;
    localparam int TOG_IDX_A = 0;  // bit 6 toggle flop
    localparam int TOG_IDX_B = 1;  // bit 2 toggle flop

    function automatic read_kind_t classify_read(op_state_t st, logic in_susp_sect);
        read_kind_t k;
        case (st)
            ST_PROG, ST_SUSP_PROG:   k = RK_PROG;
            ST_ERASE, ST_SUSP_WAIT:  k = RK_ERASE;
            ST_SUSPENDED:            k = in_susp_sect ? RK_SUSP : RK_ARRAY;
            default:                 k = RK_ARRAY;
        endcase
        return k;
    endfunction

    function automatic logic is_ready(op_state_t st);
        return (st == ST_IDLE) || (st == ST_SUSPENDED);
    endfunction

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expire,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = run && (cnt == W'(1));

    // R9
    timer_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt != '0);

endmodule

// File: rtl/flash_toggle_pair.sv
module flash_toggle_pair
    import flash_rdmux_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [NUM_TOG-1:0] flip,
    output logic [NUM_TOG-1:0] tog
);

    for (genvar i = 0; i < NUM_TOG; i++) begin : g_tog
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                tog[i] <= 1'b0;
            end else if (flip[i]) begin
                tog[i] <= ~tog[i];
            end
        end

        // R3
        toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr && !flip[i]) |=> $stable(tog[i]));
        // R4
        toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr && flip[i]) |=> tog[i] != $past(tog[i]));
    end

endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
    import flash_rdmux_pkg::*;
#(
    parameter int DW = 16
) (
    input  read_kind_t         kind,
    input  logic [DW-1:0]      array_data,
    input  logic               prog_bit7,
    input  logic [NUM_TOG-1:0] tog,
    output logic [DW-1:0]      value
);

    always_comb begin
        value = array_data;
        case (kind)
            RK_PROG: begin
                value[POLL_BIT] = ~prog_bit7;
                value[TOG_BIT]  = tog[TOG_IDX_A];
                value[STOG_BIT] = tog[TOG_IDX_B];
            end
            RK_ERASE: begin
                value[POLL_BIT] = 1'b0;
                value[TOG_BIT]  = tog[TOG_IDX_A];
                value[STOG_BIT] = tog[TOG_IDX_B];
            end
            RK_SUSP: begin
                value[POLL_BIT] = 1'b1;
                value[TOG_BIT]  = 1'b1;
                value[STOG_BIT] = tog[TOG_IDX_B];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flash_wstat_rdmux.sv
module flash_wstat_rdmux
    import flash_rdmux_pkg::*;
#(
    parameter int AW           = 20,
    parameter int DW           = 16,
    parameter int SECT_LSB     = 11,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40,
    parameter int SUSP_CYCLES  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_prog,
    input  logic          start_erase,
    input  logic          suspend_req,
    input  logic          resume_req,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          rd_strobe,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data,
    output logic          ready,
    output logic          op_done
);

    localparam int SW     = AW - SECT_LSB;
    localparam int MAXCYC = (ERASE_CYCLES > PROG_CYCLES) ?
                            ((ERASE_CYCLES > SUSP_CYCLES) ? ERASE_CYCLES : SUSP_CYCLES) :
                            ((PROG_CYCLES > SUSP_CYCLES) ? PROG_CYCLES : SUSP_CYCLES);
    localparam int CW     = $clog2(MAXCYC + 1);

    op_state_t          state, state_n;
    logic [SW-1:0]      susp_sect;
    logic               prog_bit7;
    logic               latch_prog, latch_sect;
    logic               p_load, p_run, p_exp;
    logic               e_load, e_run, e_exp;
    logic               s_load, s_run, s_exp;
    logic               tog_clr, done_n;
    logic [NUM_TOG-1:0] tog, tog_flip;
    logic [CW-1:0]      p_cnt, e_cnt, s_cnt;
    logic               rd_in_sect, cmd_in_sect;
    read_kind_t         kind;
    logic [DW-1:0]      rd_value;

    assign rd_in_sect  = (rd_addr[AW-1:SECT_LSB]  == susp_sect);
    assign cmd_in_sect = (cmd_addr[AW-1:SECT_LSB] == susp_sect);

    flash_busy_timer #(.W(CW)) u_prog_tmr (
        .clk(clk), .rst(rst), .load(p_load), .load_val(CW'(PROG_CYCLES)),
        .run(p_run), .expire(p_exp), .cnt(p_cnt)
    );

    flash_busy_timer #(.W(CW)) u_erase_tmr (
        .clk(clk), .rst(rst), .load(e_load), .load_val(CW'(ERASE_CYCLES)),
        .run(e_run), .expire(e_exp), .cnt(e_cnt)
    );

    flash_busy_timer #(.W(CW)) u_susp_tmr (
        .clk(clk), .rst(rst), .load(s_load), .load_val(CW'(SUSP_CYCLES)),
        .run(s_run), .expire(s_exp), .cnt(s_cnt)
    );

    always_comb begin
        state_n    = state;
        p_load     = 1'b0;
        e_load     = 1'b0;
        s_load     = 1'b0;
        p_run      = 1'b0;
        e_run      = 1'b0;
        s_run      = 1'b0;
        tog_clr    = 1'b0;
        done_n     = 1'b0;
        latch_prog = 1'b0;
        latch_sect = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start_prog) begin
                    state_n    = ST_PROG;
                    p_load     = 1'b1;
                    tog_clr    = 1'b1;
                    latch_prog = 1'b1;
                end else if (start_erase) begin
                    state_n    = ST_ERASE;
                    e_load     = 1'b1;
                    tog_clr    = 1'b1;
                    latch_sect = 1'b1;
                end
            end
            ST_PROG: begin
                p_run = 1'b1;
                if (p_exp) begin
                    state_n = ST_IDLE;
                    done_n  = 1'b1;
                end
            end
            ST_ERASE: begin
                e_run = 1'b1;
                if (e_exp) begin
                    state_n = ST_IDLE;
                    done_n  = 1'b1;
                end else if (suspend_req) begin
                    state_n = ST_SUSP_WAIT;
                    s_load  = 1'b1;
                end
            end
            ST_SUSP_WAIT: begin
                s_run = 1'b1;
                if (s_exp) state_n = ST_SUSPENDED;
            end
            ST_SUSPENDED: begin
                if (start_prog && !cmd_in_sect) begin
                    state_n    = ST_SUSP_PROG;
                    p_load     = 1'b1;
                    tog_clr    = 1'b1;
                    latch_prog = 1'b1;
                end else if (resume_req) begin
                    state_n = ST_ERASE;
                    tog_clr = 1'b1;
                end
            end
            ST_SUSP_PROG: begin
                p_run = 1'b1;
                if (p_exp) begin
                    state_n = ST_SUSPENDED;
                    done_n  = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            susp_sect <= '0;
            prog_bit7 <= 1'b0;
            op_done   <= 1'b0;
        end else begin
            state   <= state_n;
            op_done <= done_n;
            if (latch_sect) susp_sect <= cmd_addr[AW-1:SECT_LSB];
            if (latch_prog) prog_bit7 <= cmd_data[POLL_BIT];
        end
    end

    assign kind = classify_read(state, rd_in_sect);

    always_comb begin
        tog_flip            = '0;
        tog_flip[TOG_IDX_A] = rd_strobe && (kind == RK_PROG || kind == RK_ERASE);
        tog_flip[TOG_IDX_B] = rd_strobe && (kind == RK_ERASE || kind == RK_SUSP);
    end

    flash_toggle_pair u_tog (
        .clk(clk), .rst(rst), .clr(tog_clr), .flip(tog_flip), .tog(tog)
    );

    flash_status_mux #(.DW(DW)) u_mux (
        .kind(kind), .array_data(array_data), .prog_bit7(prog_bit7),
        .tog(tog), .value(rd_value)
    );

    always_ff @(posedge clk) begin
        if (rst)            rd_data <= '0;
        else if (rd_strobe) rd_data <= rd_value;
    end

    assign ready = is_ready(state);

    // R6
    ready_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && (start_prog || start_erase)) |=> !ready);
    // R9
    op_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done);
    // R5
    susp_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && state == ST_SUSPENDED && rd_in_sect) |=> (rd_data[POLL_BIT] && rd_data[TOG_BIT]));
    // R7
    reset_ready_chk: assert property (@(posedge clk)
        rst |=> (ready && !op_done));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG && start_erase) |=> state != ST_ERASE);
    // R13
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rd_data));

endmodule

// File: tb/flash_wstat_rdmux_tb.sv
module flash_wstat_rdmux_tb;

    localparam int AW = 20, DW = 16, SL = 11;
    localparam int PC = 8, EC = 40, SC = 6;

    logic          clk = 1'b0, rst = 1'b1;
    logic          start_prog = 0, start_erase = 0, suspend_req = 0, resume_req = 0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [DW-1:0] cmd_data = '0, array_data = '0, rd_data;
    logic          rd_strobe = 0, ready, op_done;

    int checks = 0, errors = 0, cyc = 0;
    bit model_on = 0, finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    flash_wstat_rdmux #(.AW(AW), .DW(DW), .SECT_LSB(SL), .PROG_CYCLES(PC),
                        .ERASE_CYCLES(EC), .SUSP_CYCLES(SC)) u_dut (
        .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
        .suspend_req(suspend_req), .resume_req(resume_req), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
        .array_data(array_data), .rd_data(rd_data), .ready(ready), .op_done(op_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 idle 1 prog 2 erase 3 suspend-wait 4 suspended 5 suspend-prog
    int m_mode = 0, p_left = 0, e_left = 0, s_left = 0, m_sect = 0;
    bit m_pd7 = 0, t6 = 0, t2 = 0, m_done = 0;
    logic [15:0] m_rd = '0;
    string m_tag = "R7";

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_mode = 0; t6 = 0; t2 = 0; m_rd = '0; m_done = 0; m_tag = "R7";
        end else begin
            m_done = 0;
            if (rd_strobe) begin
                logic [15:0] v;
                v = array_data;
                m_tag = "R13 array";
                if (m_mode == 1 || m_mode == 5) begin
                    v[7] = ~m_pd7; v[6] = t6; v[2] = t2; t6 = ~t6; m_tag = "R1 program read";
                end else if (m_mode == 2 || m_mode == 3) begin
                    v[7] = 1'b0; v[6] = t6; v[2] = t2; t6 = ~t6; t2 = ~t2; m_tag = "R2 erase read";
                end else if (m_mode == 4 && int'(rd_addr >> SL) == m_sect) begin
                    v[7] = 1'b1; v[6] = 1'b1; v[2] = t2; t2 = ~t2; m_tag = "R5 suspended read";
                end
                m_rd = v;
            end
            case (m_mode)
                0: if (start_prog) begin
                       m_mode = 1; p_left = PC; m_pd7 = cmd_data[7]; t6 = 0; t2 = 0;
                   end else if (start_erase) begin
                       m_mode = 2; e_left = EC; m_sect = int'(cmd_addr >> SL); t6 = 0; t2 = 0;
                   end
                1: begin p_left--; if (p_left == 0) begin m_mode = 0; m_done = 1; end end
                2: begin
                       e_left--;
                       if (e_left == 0) begin m_mode = 0; m_done = 1; end
                       else if (suspend_req) begin m_mode = 3; s_left = SC; end
                   end
                3: begin s_left--; if (s_left == 0) m_mode = 4; end
                4: if (start_prog && int'(cmd_addr >> SL) != m_sect) begin
                       m_mode = 5; p_left = PC; m_pd7 = cmd_data[7]; t6 = 0; t2 = 0;
                   end else if (resume_req) begin
                       m_mode = 2; t6 = 0; t2 = 0;
                   end
                5: begin p_left--; if (p_left == 0) begin m_mode = 4; m_done = 1; end end
                default: m_mode = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (model_on && !finished) begin
            chk("R6 ready vs model", ready, (m_mode == 0 || m_mode == 4));
            chk("R9 op_done vs model", op_done, m_done);
            chk(m_tag, rd_data, m_rd);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    task automatic go_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        start_prog = 1; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        start_prog = 0;
    endtask

    task automatic go_erase(input logic [AW-1:0] a);
        start_erase = 1; cmd_addr = a;
        @(negedge clk);
        start_erase = 0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic [DW-1:0] q);
        rd_strobe = 1; rd_addr = a; array_data = d;
        @(negedge clk);
        rd_strobe = 0;
        q = rd_data;
    endtask

    task automatic wait_done(output int at);
        int n = 0;
        while (!op_done && n < 200) begin @(negedge clk); n++; end
        at = cyc;
    endtask

    initial begin
        logic [DW-1:0] q;
        int t0, t1, ts, tr, remain, seen;
        repeat (3) @(negedge clk);
        rst = 0;
        model_on = 1;
        // R7 reset state
        chk("R7 reset ready", ready, 1);
        chk("R7 reset rd_data", rd_data, 0);
        chk("R7 reset op_done", op_done, 0);

        // program
        go_prog(20'h00100, 16'h00A5); t0 = cyc;
        chk("R6 ready low in program", ready, 0);
        do_read(20'h00100, 16'hFFFF, q); chk("R1 inverted bit7, R3 first bit6=0", q, 16'hFF3B);
        do_read(20'h00100, 16'hFFFF, q); chk("R3 bit6 toggled, R4 bit2 held", q, 16'hFF7B);
        do_read(20'h00100, 16'hFFFF, q); chk("R3 bit6 back", q, 16'hFF3B);
        @(negedge clk); chk("R13 rd_data holds", rd_data, 16'hFF3B);
        wait_done(t1); chk("R9 program duration", t1 - t0, PC);
        @(negedge clk); chk("R9 op_done single cycle", op_done, 0);
        do_read(20'h00100, 16'h00A5, q); chk("R1 true data after program", q, 16'h00A5);
        chk("R6 ready after program", ready, 1);

        // erase, ignored command, suspend
        go_erase(20'h01800); t0 = cyc;
        do_read(20'h01800, 16'hFFFF, q); chk("R2 erase bit7=0", q, 16'hFF3B);
        do_read(20'h01800, 16'hFFFF, q); chk("R4 bit2 toggles in erase", q, 16'hFF7F);
        go_prog(20'h04000, 16'h0000);
        chk("R10 program during erase ignored", ready, 0);
        suspend_req = 1; @(negedge clk); suspend_req = 0; ts = cyc;
        remain = EC - (ts - t0);
        chk("R6 ready low in suspend latency", ready, 0);
        while (!ready && cyc - ts < 50) @(negedge clk);
        chk("R8 suspend latency", cyc - ts, SC);
        do_read(20'h01801, 16'h1234, q); chk("R5 in-sector status", q, 16'h12F0);
        do_read(20'h01801, 16'h1234, q); chk("R5 bit2 toggles in sector", q, 16'h12F4);
        do_read(20'h02000, 16'h1234, q); chk("R5 other sector true data", q, 16'h1234);

        // program in suspend
        go_prog(20'h01820, 16'h0000);
        chk("R11 same-sector program ignored", ready, 1);
        go_prog(20'h04000, 16'h0011); t0 = cyc;
        chk("R11 other-sector program busy", ready, 0);
        do_read(20'h04000, 16'hFFFF, q); chk("R1 suspend program bit7", q, 16'hFFBB);
        wait_done(t1); chk("R11 suspend program duration", t1 - t0, PC);
        chk("R11 back to suspended", ready, 1);
        do_read(20'h01800, 16'h0000, q); chk("R11 still suspended", q[7:6], 2'b11);

        // resume
        resume_req = 1; @(negedge clk); resume_req = 0; tr = cyc;
        chk("R12 resume busy", ready, 0);
        do_read(20'h01800, 16'hFFFF, q); chk("R12 toggles cleared on resume", q, 16'hFF3B);
        wait_done(t1); chk("R12 remaining erase count", t1 - tr, remain);
        do_read(20'h01800, 16'hFFFF, q); chk("R2 true data after erase", q, 16'hFFFF);

        // priority when both starts arrive
        start_prog = 1; start_erase = 1; cmd_addr = 20'h00200; cmd_data = 16'h0080;
        @(negedge clk); start_prog = 0; start_erase = 0; t0 = cyc;
        wait_done(t1); chk("R10 program wins over erase", t1 - t0, PC);

        // reset mid-erase
        go_erase(20'h01800);
        repeat (2) @(negedge clk);
        rst = 1; @(negedge clk); rst = 0;
        chk("R7 ready after reset", ready, 1);
        seen = 0;
        repeat (EC + 5) begin @(negedge clk); if (op_done) seen++; end
        chk("R7 no completion after reset", seen, 0);
        do_read(20'h01800, 16'h5A5A, q); chk("R7 read mode after reset", q, 16'h5A5A);

        summary();
    end

endmodule